// File: doc/BRIEF.md
# Shadow Scan Register Chain

This block is the target side of a serial debug link into a small CPU. It holds a 64-bit scan chain that shadows the CPU's state: an 8-bit control byte, four 8-bit general-register shadows, an 8-bit program-counter shadow and a 16-bit instruction shadow. A host drives a serial clock and a data line. On each rising serial edge the chain either shifts one bit in at the instruction end, or takes a parallel snapshot of the CPU registers. The bit at the control end is presented on the serial output.

The snapshot is armed by the CPU's own clock. A falling CPU clock edge sets a load enable. The next rising serial edge loads every shadow except the control byte, and the first falling serial edge after that load clears the enable again. Two bits of the control byte let the host take over instruction decoding. One makes the decoder use the instruction shadow in place of the real instruction register. The other suppresses the decoder's register-load strobes and asks for the real instruction register to be loaded from the shadow.

Both incoming clocks are sampled by one fabric clock, resynchronised and turned into single-cycle edge events, so the whole block runs in a single clock domain.

Top module: `shadow_scan_chain`

## Requirements
- R1: After reset the serial output is 0, the load enable is clear, and every shadow and the control byte read as zero on a scan. With the control byte at zero, the decoder instruction output follows `cpu_ir`, the load strobes pass through unchanged and `ir_from_shadow` is 0.
- R2: On a rising serial edge with the load enable clear, the chain shifts toward the control end and `scan_in` enters at bit 0 (the instruction-shadow LSB). After 64 such edges the chain holds the 64 bits sent, with the first bit sent in chain bit 63.
- R3: A falling edge of `cpu_clk` sets the load enable. The next rising serial edge then loads the chain from the CPU registers instead of shifting. From MSB down, the 56-bit layout below the control byte is R0, R1, R2, R3 (8 bits each), PC (8) and IR (16).
- R4: The load enable clears on the first falling serial edge after a load, so later rising serial edges shift and do not reload.
- R5: A parallel load leaves the control byte (chain bits 63..56) at its previously shifted-in value.
- R6: `scan_out` changes only on a falling serial edge, when it takes the chain's bit 63.
- R7: While control bit 1 is set, `dec_ir` carries the instruction shadow (chain bits 15..0). Otherwise it carries `cpu_ir`.
- R8: While control bit 2 is set, `dec_load_out` is all zeros and `ir_from_shadow` is 1. Otherwise `dec_load_out` equals `dec_load_in` and `ir_from_shadow` is 0.
- R9: If a falling CPU clock edge and a falling serial edge land in the same cycle after a load, setting the enable wins, and the next rising serial edge loads again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples everything |
| rst | input | 1 | Synchronous active-high reset |
| scan_clk | input | 1 | Serial clock from the host |
| cpu_clk | input | 1 | CPU clock, used to arm the snapshot |
| scan_in | input | 1 | Serial data from the host |
| scan_out | output | 1 | Serial data to the host (chain bit 63) |
| cpu_gpr | input | 32 | General registers, R0 in bits 7..0, R3 in bits 31..24 |
| cpu_pc | input | 8 | CPU program counter |
| cpu_ir | input | 16 | CPU instruction register |
| dec_load_in | input | 8 | Register-load strobes from the decoder |
| dec_ir | output | 16 | Instruction word handed to the decoder |
| dec_load_out | output | 8 | Load strobes after gating |
| ir_from_shadow | output | 1 | Request to load the real IR from the shadow |

## Verification
The enable is set by the CPU's falling edge and cleared by the serial clock's falling edge after a load, so these two events can fall in the same fabric cycle. The bench lowers both clock lines on the same fabric edge just after a snapshot. Both pass through identical synchronisers, so the two edge events coincide. It then changes the CPU register values and gives one more serial pulse. A complete scan-out must then return the new values, with the control byte unchanged. If the clear had won, that pulse would have shifted the older snapshot by one bit. A second pairing, a rising serial edge that loads while the control byte changes, is judged by reading back the control byte after the load.

// File: rtl/shadow_scan_pkg.sv
package shadow_scan_pkg;
  // bit positions inside the control byte that the decoder side reacts to
  localparam int CTRL_REDIRECT_BIT = 1;
  localparam int CTRL_GATE_BIT     = 2;

  typedef enum logic [1:0] {
    CHAIN_HOLD  = 2'd0,
    CHAIN_SHIFT = 2'd1,
    CHAIN_LOAD  = 2'd2
  } chain_op_e;
endpackage

// File: rtl/scan_edge_sync.sv
module scan_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/scan_load_ctrl.sv
module scan_load_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cpu_fall,
  input  logic sclk_rise,
  input  logic sclk_fall,
  output logic load_en
);
  logic loaded_q;

  // a CPU fall always arms; the clear needs a completed load first
  always_ff @(posedge clk) begin
    if (rst) begin
      load_en  <= 1'b0;
      loaded_q <= 1'b0;
    end else if (cpu_fall) begin
      load_en  <= 1'b1;
      loaded_q <= 1'b0;
    end else if (sclk_rise && load_en) begin
      loaded_q <= 1'b1;
    end else if (sclk_fall && loaded_q) begin
      load_en  <= 1'b0;
      loaded_q <= 1'b0;
    end
  end

  assert_arm_on_cpu_fall_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_fall |=> load_en);
  assert_clear_after_load_R4: assert property (@(posedge clk) disable iff (rst)
    (sclk_fall && loaded_q && !cpu_fall) |=> !load_en);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_fall && sclk_fall) |=> (load_en && !loaded_q));
endmodule

// File: rtl/scan_chain_core.sv
module scan_chain_core
  import shadow_scan_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int DATA_W = 56,
  localparam int TOTAL = CTRL_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              load_en,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] par_in,
  output logic [TOTAL-1:0]  chain,
  output logic              ser_out
);
  chain_op_e op;

  always_comb begin
    op = CHAIN_HOLD;
    if (sclk_rise) op = load_en ? CHAIN_LOAD : CHAIN_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      case (op)
        CHAIN_SHIFT: chain <= {chain[TOTAL-2:0], ser_in};
        CHAIN_LOAD:  chain <= {chain[TOTAL-1:DATA_W], par_in};
        default:     chain <= chain;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ser_out <= 1'b0;
    else if (sclk_fall) ser_out <= chain[TOTAL-1];
  end

  assert_shift_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !load_en) |=> (chain[0] == $past(ser_in)
                                 && chain[TOTAL-1:1] == $past(chain[TOTAL-2:0])));
  assert_load_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && load_en) |=> chain[DATA_W-1:0] == $past(par_in));
  assert_ctrl_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && load_en) |=> $stable(chain[TOTAL-1:DATA_W]));
  assert_out_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    !sclk_fall |=> $stable(ser_out));
endmodule

// File: rtl/scan_decode_override.sv
module scan_decode_override #(
  parameter int IR_W  = 16,
  parameter int NLOAD = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             redirect,
  input  logic             gate,
  input  logic [IR_W-1:0]  shadow_ir,
  input  logic [IR_W-1:0]  cpu_ir,
  input  logic [NLOAD-1:0] load_in,
  output logic [IR_W-1:0]  dec_ir,
  output logic [NLOAD-1:0] load_out,
  output logic             ir_from_shadow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_ir         <= '0;
      load_out       <= '0;
      ir_from_shadow <= 1'b0;
    end else begin
      dec_ir         <= redirect ? shadow_ir : cpu_ir;
      load_out       <= gate ? '0 : load_in;
      ir_from_shadow <= gate;
    end
  end

  assert_redirect_R7: assert property (@(posedge clk) disable iff (rst)
    redirect |=> dec_ir == $past(shadow_ir));
  assert_gate_R8: assert property (@(posedge clk) disable iff (rst)
    gate |=> (load_out == '0 && ir_from_shadow));
endmodule

// File: rtl/shadow_scan_chain.sv
module shadow_scan_chain
  import shadow_scan_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int NUM_GPR     = 4,
  parameter int PC_W        = 8,
  parameter int IR_W        = 16,
  parameter int CTRL_W      = 8,
  parameter int NLOAD       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scan_clk,
  input  logic                     cpu_clk,
  input  logic                     scan_in,
  output logic                     scan_out,
  input  logic [NUM_GPR*REG_W-1:0] cpu_gpr,
  input  logic [PC_W-1:0]          cpu_pc,
  input  logic [IR_W-1:0]          cpu_ir,
  input  logic [NLOAD-1:0]         dec_load_in,
  output logic [IR_W-1:0]          dec_ir,
  output logic [NLOAD-1:0]         dec_load_out,
  output logic                     ir_from_shadow
);
  localparam int GPR_BITS = NUM_GPR * REG_W;
  localparam int DATA_W   = GPR_BITS + PC_W + IR_W;
  localparam int TOTAL    = CTRL_W + DATA_W;
  localparam int GPR_BASE = PC_W + IR_W;

  logic sclk_rise, sclk_fall, cpu_rise_unused, cpu_fall, load_en;
  logic [DATA_W-1:0] snap;
  logic [TOTAL-1:0]  chain;

  scan_edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_edge (
    .clk(clk), .rst(rst), .async_in(scan_clk), .rise(sclk_rise), .fall(sclk_fall));
  scan_edge_sync #(.STAGES(SYNC_STAGES)) u_cpu_edge (
    .clk(clk), .rst(rst), .async_in(cpu_clk), .rise(cpu_rise_unused), .fall(cpu_fall));

  scan_load_ctrl u_load (
    .clk(clk), .rst(rst), .cpu_fall(cpu_fall), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .load_en(load_en));

  // R0 sits next to the control byte, the highest-numbered register next to PC
  generate
    for (genvar k = 0; k < NUM_GPR; k++) begin : g_gpr
      assign snap[GPR_BASE + (NUM_GPR-1-k)*REG_W +: REG_W] = cpu_gpr[k*REG_W +: REG_W];
    end
  endgenerate
  assign snap[IR_W +: PC_W] = cpu_pc;
  assign snap[IR_W-1:0]     = cpu_ir;

  scan_chain_core #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_chain (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .load_en(load_en), .ser_in(scan_in), .par_in(snap), .chain(chain),
    .ser_out(scan_out));

  scan_decode_override #(.IR_W(IR_W), .NLOAD(NLOAD)) u_override (
    .clk(clk), .rst(rst),
    .redirect(chain[DATA_W + CTRL_REDIRECT_BIT]),
    .gate(chain[DATA_W + CTRL_GATE_BIT]),
    .shadow_ir(chain[IR_W-1:0]), .cpu_ir(cpu_ir), .load_in(dec_load_in),
    .dec_ir(dec_ir), .load_out(dec_load_out), .ir_from_shadow(ir_from_shadow));

  // a CPU rising edge has no function; keep it observed so it is not dangling
  assert_cpu_rise_inert_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_rise_unused && !cpu_fall && !load_en) |=> !load_en);
endmodule

// File: tb/shadow_scan_chain_bench.sv
module shadow_scan_chain_bench;
  localparam int PH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_clk = 1'b0, cpu_clk = 1'b0, scan_in = 1'b0;
  logic        scan_out;
  logic [31:0] cpu_gpr = '0;
  logic [7:0]  cpu_pc = '0;
  logic [15:0] cpu_ir = '0;
  logic [7:0]  dec_load_in = '0;
  logic [15:0] dec_ir;
  logic [7:0]  dec_load_out;
  logic        ir_from_shadow;

  int n_checks = 0, n_fail = 0;
  logic [63:0] cap;

  always #5 clk = ~clk;

  shadow_scan_chain u_shadow_scan_chain (
    .clk(clk), .rst(rst), .scan_clk(scan_clk), .cpu_clk(cpu_clk),
    .scan_in(scan_in), .scan_out(scan_out), .cpu_gpr(cpu_gpr), .cpu_pc(cpu_pc),
    .cpu_ir(cpu_ir), .dec_load_in(dec_load_in), .dec_ir(dec_ir),
    .dec_load_out(dec_load_out), .ir_from_shadow(ir_from_shadow));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (PH) @(negedge clk);
  endtask

  task automatic pulse_sclk();
    @(negedge clk) scan_clk = 1'b1; settle();
    @(negedge clk) scan_clk = 1'b0; settle();
  endtask

  task automatic pulse_cpu();
    @(negedge clk) cpu_clk = 1'b1; settle();
    @(negedge clk) cpu_clk = 1'b0; settle();
  endtask

  // first bit sent and first bit read are both chain bit 63
  task automatic scan(input logic [63:0] w, output logic [63:0] got);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk) scan_in = w[63-i];
      got[63-i] = scan_out;
      pulse_sclk();
    end
  endtask

  function automatic logic [63:0] expect_load(input logic [7:0] c);
    return {c, cpu_gpr[7:0], cpu_gpr[15:8], cpu_gpr[23:16], cpu_gpr[31:24],
            cpu_pc, cpu_ir};
  endfunction

  task automatic t_reset();
    cpu_ir = 16'h5A5A; dec_load_in = 8'hC3; settle();
    check(scan_out == 1'b0, "R1 scan_out", {63'd0, scan_out}, 64'd0);
    check(dec_ir == 16'h5A5A, "R1 dec_ir", {48'd0, dec_ir}, 64'h5A5A);
    check(dec_load_out == 8'hC3 && !ir_from_shadow, "R1 strobes",
          {55'd0, ir_from_shadow, dec_load_out}, 64'hC3);
    scan(64'd0, cap);
    check(cap == 64'd0, "R1 shadows zero", cap, 64'd0);
  endtask

  task automatic t_shift();
    scan(64'h01A53C960FE17B2D, cap);
    scan(64'h88_7766_5544_3322, cap);
    check(cap == 64'h01A53C960FE17B2D, "R2 shift round trip", cap, 64'h01A53C960FE17B2D);
    scan(64'd0, cap);
    check(cap == 64'h0088776655443322, "R2 second pattern", cap, 64'h0088776655443322);
  endtask

  task automatic t_load();
    logic [63:0] exp;
    scan(64'h1800_0000_0000_0000, cap);
    cpu_gpr = 32'h44332211; cpu_pc = 8'h5E; cpu_ir = 16'hA0B1;
    exp = expect_load(8'h18);
    pulse_cpu();
    pulse_sclk();
    cpu_gpr = 32'hFFFFFFFF; cpu_pc = 8'hFF; cpu_ir = 16'hFFFF;
    scan(64'd0, cap);
    check(cap[55:0] == exp[55:0], "R3 snapshot", cap, exp);
    check(cap[63:56] == 8'h18, "R5 control kept", {56'd0, cap[63:56]}, 64'h18);
    check(cap == exp, "R4 no reload during scan", cap, exp);
  endtask

  task automatic t_out_edge();
    scan(64'h4000_0000_0000_0000, cap);
    check(scan_out == 1'b0, "R6 out before", {63'd0, scan_out}, 64'd0);
    @(negedge clk) scan_clk = 1'b1; settle();
    check(scan_out == 1'b0, "R6 held over rise", {63'd0, scan_out}, 64'd0);
    @(negedge clk) scan_clk = 1'b0; settle();
    check(scan_out == 1'b1, "R6 updated on fall", {63'd0, scan_out}, 64'd1);
    scan(64'd0, cap);
  endtask

  task automatic t_redirect();
    cpu_ir = 16'h1234;
    scan(64'h0200_0000_0000_BEEF, cap);
    settle();
    check(dec_ir == 16'hBEEF, "R7 shadow IR used", {48'd0, dec_ir}, 64'hBEEF);
    scan(64'h0000_0000_0000_BEEF, cap);
    settle();
    check(dec_ir == 16'h1234, "R7 real IR used", {48'd0, dec_ir}, 64'h1234);
  endtask

  task automatic t_gate();
    dec_load_in = 8'hFF;
    scan(64'h0400_0000_0000_0000, cap);
    settle();
    check(dec_load_out == 8'h00 && ir_from_shadow, "R8 gated",
          {55'd0, ir_from_shadow, dec_load_out}, 64'h100);
    scan(64'd0, cap);
    settle();
    check(dec_load_out == 8'hFF && !ir_from_shadow, "R8 released",
          {55'd0, ir_from_shadow, dec_load_out}, 64'hFF);
  endtask

  task automatic t_coincide();
    logic [63:0] exp;
    scan(64'h4000_0000_0000_0000, cap);
    cpu_gpr = 32'h0A0B0C0D; cpu_pc = 8'h11; cpu_ir = 16'h2222;
    pulse_cpu();
    @(negedge clk) scan_clk = 1'b1; settle();
    @(negedge clk) cpu_clk = 1'b1; settle();
    @(negedge clk) begin cpu_clk = 1'b0; scan_clk = 1'b0; end
    settle();
    cpu_gpr = 32'hD1C2B3A4; cpu_pc = 8'h77; cpu_ir = 16'h6E5F;
    exp = expect_load(8'h40);
    pulse_sclk();
    scan(64'd0, cap);
    check(cap == exp, "R9 set wins over clear", cap, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_shift();
    t_load();
    t_out_edge();
    t_redirect();
    t_gate();
    t_coincide();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule